// File: doc/BRIEF.md
# Programmable Address Window Router

This block sits behind a processor's memory port and steers every transaction address to one of two downstream ports. Port M0 leads to the general on-chip interconnect and port M1 leads to the SDRAM controller. Software sets a lower and an upper boundary, both counted in 1 MB pages. Any address whose page lies at or above the lower boundary and below the upper one is sent to the SDRAM port. All other addresses go to the interconnect.

The routing decision is laid over a fixed map of the 4 GB space. The map has a 960 MB window for fabric-side slaves from 0xC000_0000 up to 0xFC00_0000, and peripheral space from 0xFC00_0000 to the top. Each routed request carries a region tag next to its port select. The tag is set by the programmable window first and by the fixed map second. The same window applies to requests from either of the two processor cores. The core identifier only passes through the block.

Every accepted request appears on the output one clock later as a registered, one-hot port request. A boundary write takes effect at the clock edge that completes it. A request sampled at that same edge is therefore routed with the old boundaries.

Top module: `addr_window_router`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_m0_req and out_m1_req are 0. After reset the lower boundary is page 0x000 and the upper boundary is page 0xC00, so the lowest 3 GB route to M1.
- R2: A request sampled with req_valid high at a clock edge appears on the outputs at that same edge, with out_valid high and out_addr and out_core equal to the request's values. out_valid is low in the cycle after an edge where req_valid was low.
- R3: If page = req_addr[31:20] satisfies lower <= page < upper, the request raises out_m1_req and carries region tag 1 (sdram). This holds whatever fixed region the address lies in.
- R4: Any request outside the window raises out_m0_req and not out_m1_req. For every valid output exactly one of the two port requests is high.
- R5: If upper <= lower, the window is empty and every request routes to M0.
- R6: A request outside the window whose address is in [0xC000_0000, 0xFC00_0000) carries region tag 2 (fabric slaves).
- R7: A request outside the window whose address is at or above 0xFC00_0000 carries region tag 3 (peripherals).
- R8: A request outside the window and below 0xC000_0000 carries region tag 0 (other).
- R9: A boundary write with cfg_we high takes effect at the edge that samples it. A request sampled at that same edge uses the previous boundaries, and the next request uses the new ones.
- R10: The routing and tag do not depend on req_core. Both cores see the same window.
- R11: cfg_sel 0 writes the lower boundary and cfg_sel 1 writes the upper boundary. cfg_data is a 13-bit page count, so an upper value of 0x1000 covers the whole 4 GB space.
- R12: Address bits [19:0] do not affect routing or the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_sel | input | 1 | 0 selects the lower boundary, 1 the upper |
| cfg_data | input | 13 | Boundary value in 1 MB pages |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_core | input | 1 | Issuing core |
| out_valid | output | 1 | Routed request present |
| out_m0_req | output | 1 | Request to the interconnect port |
| out_m1_req | output | 1 | Request to the SDRAM port |
| out_region | output | 2 | Region tag: 0 other, 1 sdram, 2 fabric slaves, 3 peripherals |
| out_addr | output | 32 | Routed address |
| out_core | output | 1 | Routed core identifier |

## Verification
A boundary write and a request can land on the same clock edge. That is the one case where the order of the two actions decides the route. The bench forces it on purpose: it moves the upper boundary below a request's page in the very cycle the request is presented, then repeats the request on the next cycle. It expects the first routing to follow the old window and the second the new one. A long random phase adds writes at about one cycle in eight, in the same cycles as requests. Every output is compared against a behavioural model that applies its boundary update only after computing that cycle's route.

// File: rtl/awr_pkg.sv
package awr_pkg;
  typedef enum logic [1:0] {
    RGN_OTHER  = 2'd0,
    RGN_SDRAM  = 2'd1,
    RGN_FABRIC = 2'd2,
    RGN_PERIPH = 2'd3
  } region_e;
endpackage

// File: rtl/awr_bound_regs.sv
module awr_bound_regs #(
  parameter int PAGE_W    = 12,
  parameter int LOW_RST   = 0,
  parameter int HIGH_RST  = 'hC00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [PAGE_W:0] wr_val,
  output logic [PAGE_W:0] low_q,
  output logic [PAGE_W:0] high_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= (PAGE_W+1)'(LOW_RST);
      high_q <= (PAGE_W+1)'(HIGH_RST);
    end else if (wr_en) begin
      if (wr_sel) high_q <= wr_val;
      else        low_q  <= wr_val;
    end
  end
endmodule

// File: rtl/awr_region_decode.sv
module awr_region_decode
  import awr_pkg::*;
#(
  parameter int PAGE_W    = 12,
  parameter int FABRIC_PG = 'hC00,
  parameter int PERIPH_PG = 'hFC0
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W:0]   low_b,
  input  logic [PAGE_W:0]   high_b,
  output logic              win_hit,
  output region_e           region
);
  logic [PAGE_W:0] page_x;
  assign page_x = {1'b0, page};

  always_comb begin
    win_hit = (page_x >= low_b) && (page_x < high_b);
    if (win_hit)
      region = RGN_SDRAM;
    else if (page_x >= (PAGE_W+1)'(PERIPH_PG))
      region = RGN_PERIPH;
    else if (page_x >= (PAGE_W+1)'(FABRIC_PG))
      region = RGN_FABRIC;
    else
      region = RGN_OTHER;
  end
endmodule

// File: rtl/awr_route_stage.sv
module awr_route_stage
  import awr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CORE_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_hit,
  input  region_e           in_region,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CORE_W-1:0] in_core,
  output logic              o_valid,
  output logic              o_m0,
  output logic              o_m1,
  output logic [1:0]        o_region,
  output logic [ADDR_W-1:0] o_addr,
  output logic [CORE_W-1:0] o_core
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid  <= 1'b0;
      o_m0     <= 1'b0;
      o_m1     <= 1'b0;
      o_region <= 2'd0;
      o_addr   <= '0;
      o_core   <= '0;
    end else begin
      o_valid  <= in_valid;
      o_m0     <= in_valid && !in_hit;
      o_m1     <= in_valid && in_hit;
      o_region <= in_region;
      o_addr   <= in_addr;
      o_core   <= in_core;
    end
  end
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
  import awr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 20,
  parameter int NUM_CORES = 2,
  parameter int FABRIC_PG = 'hC00,
  parameter int PERIPH_PG = 'hFC0,
  parameter int LOW_RST   = 0,
  parameter int HIGH_RST  = 'hC00,
  localparam int PAGE_W   = ADDR_W - GRAN_LOG2,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [PAGE_W:0]   cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  output logic              out_valid,
  output logic              out_m0_req,
  output logic              out_m1_req,
  output logic [1:0]        out_region,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CORE_W-1:0] out_core
);
  logic [PAGE_W:0] bnd_low;
  logic [PAGE_W:0] bnd_high;
  logic            dec_hit;
  region_e         dec_region;

  awr_bound_regs #(.PAGE_W(PAGE_W), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_val(cfg_data),
    .low_q(bnd_low), .high_q(bnd_high)
  );

  awr_region_decode #(.PAGE_W(PAGE_W), .FABRIC_PG(FABRIC_PG), .PERIPH_PG(PERIPH_PG)) u_dec (
    .page(req_addr[ADDR_W-1:GRAN_LOG2]), .low_b(bnd_low), .high_b(bnd_high),
    .win_hit(dec_hit), .region(dec_region)
  );

  awr_route_stage #(.ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_stage (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_hit(dec_hit),
    .in_region(dec_region), .in_addr(req_addr), .in_core(req_core),
    .o_valid(out_valid), .o_m0(out_m0_req), .o_m1(out_m1_req),
    .o_region(out_region), .o_addr(out_addr), .o_core(out_core)
  );
endmodule

// File: rtl/awr_checker.sv
module awr_checker #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 20,
  parameter int CORE_W    = 1,
  parameter int PERIPH_PG = 'hFC0,
  localparam int PAGE_W   = ADDR_W - GRAN_LOG2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CORE_W-1:0] req_core,
  input logic [PAGE_W:0]   low_q,
  input logic [PAGE_W:0]   high_q,
  input logic              out_valid,
  input logic              out_m0_req,
  input logic              out_m1_req,
  input logic [1:0]        out_region,
  input logic [ADDR_W-1:0] out_addr,
  input logic [CORE_W-1:0] out_core
);
  logic [PAGE_W:0] req_pg;
  logic [PAGE_W:0] out_pg;
  assign req_pg = {1'b0, req_addr[ADDR_W-1:GRAN_LOG2]};
  assign out_pg = {1'b0, out_addr[ADDR_W-1:GRAN_LOG2]};

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !out_valid && !out_m0_req && !out_m1_req);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid && out_addr == $past(req_addr) && out_core == $past(req_core));

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !out_valid);

  a_r4_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_m0_req, out_m1_req}) && (out_valid == (out_m0_req || out_m1_req)));

  a_r3_m1_means_sdram: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_m1_req == (out_region == 2'd1)));

  a_r9_old_bounds_used: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_m1_req == ($past(req_pg) >= $past(low_q) && $past(req_pg) < $past(high_q)));

  a_r5_empty_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && high_q <= low_q) |=> out_m0_req);

  a_r7_periph_tag: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_m1_req && out_pg >= (PAGE_W+1)'(PERIPH_PG)) |-> out_region == 2'd3);
endmodule

bind addr_window_router awr_checker #(
  .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .CORE_W(CORE_W), .PERIPH_PG(PERIPH_PG)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_core(req_core),
  .low_q(bnd_low), .high_q(bnd_high), .out_valid(out_valid), .out_m0_req(out_m0_req),
  .out_m1_req(out_m1_req), .out_region(out_region), .out_addr(out_addr), .out_core(out_core)
);

// File: tb/addr_window_router_test.sv
module addr_window_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [12:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [0:0]  req_core = '0;
  logic        out_valid, out_m0_req, out_m1_req;
  logic [1:0]  out_region;
  logic [31:0] out_addr;
  logic [0:0]  out_core;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int ref_lo, ref_hi;
  bit exp_valid, exp_m1, exp_empty;
  int exp_region;
  logic [31:0] exp_addr;
  logic [0:0]  exp_core;

  always #2 clk = ~clk;

  addr_window_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_core(req_core),
    .out_valid(out_valid), .out_m0_req(out_m0_req), .out_m1_req(out_m1_req),
    .out_region(out_region), .out_addr(out_addr), .out_core(out_core)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural model: route first, then apply the write
  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 0; ref_lo = 0; ref_hi = 'hC00;
    end else begin
      int pg;
      pg = int'(req_addr >> 20);
      exp_valid = req_valid;
      exp_empty = (ref_hi <= ref_lo);
      exp_m1 = (pg >= ref_lo) && (pg < ref_hi);
      exp_region = exp_m1 ? 1 : (pg >= 'hFC0) ? 3 : (pg >= 'hC00) ? 2 : 0;
      exp_addr = req_addr;
      exp_core = req_core;
      if (cfg_we) begin
        if (cfg_sel) ref_hi = int'(cfg_data);
        else         ref_lo = int'(cfg_data);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == exp_valid, "R2 valid", out_valid, exp_valid);
      if (exp_valid) begin
        check(out_m1_req == exp_m1, exp_m1 ? "R3 port" : (exp_empty ? "R5 port" : "R4 port"),
              out_m1_req, exp_m1);
        check(out_m0_req == !exp_m1, "R4 m0", out_m0_req, !exp_m1);
        check(int'(out_region) == exp_region,
              exp_region == 1 ? "R3 tag" : exp_region == 2 ? "R6 tag" :
              exp_region == 3 ? "R7 tag" : "R8 tag", out_region, exp_region);
        check(out_addr == exp_addr, "R2 addr", out_addr, exp_addr);
        check(out_core == exp_core, "R10 core", out_core, exp_core);
      end else begin
        check(!out_m0_req && !out_m1_req, "R2 idle ports", {out_m0_req, out_m1_req}, 0);
      end
    end
  end

  task automatic drive(input bit v, input logic [31:0] a, input bit c,
                       input bit we, input bit sel, input int d);
    @(negedge clk);
    req_valid = v; req_addr = a; req_core = c;
    cfg_we = we; cfg_sel = sel; cfg_data = 13'(d);
  endtask

  task automatic rq(input logic [31:0] a, input bit c);
    drive(1, a, c, 0, 0, 0);
  endtask

  task automatic wr(input bit sel, input int d);
    drive(0, 32'h0, 0, 1, sel, d);
  endtask

  // directed: present, then look at the outputs one edge later
  task automatic probe(input logic [31:0] a, input bit c, output bit m1, output int rg);
    rq(a, c);
    @(negedge clk);
    m1 = out_m1_req; rg = int'(out_region);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit m1a, m1b;
    int rga, rgb;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check(!out_valid && !out_m0_req && !out_m1_req, "R1 idle in reset", out_valid, 0);
    rst = 0;
    @(negedge clk);
    check(!out_valid && !out_m0_req && !out_m1_req, "R1 idle after reset", out_valid, 0);
    // R1: default window is the low 3 GB
    probe(32'hBFFF_FFFF, 0, m1a, rga);
    check(m1a == 1, "R1 default window top", m1a, 1);
    probe(32'hC000_0000, 1, m1a, rga);
    check(m1a == 0 && rga == 2, "R1 default window end", rga, 2);
    // R10: both cores see the same window
    probe(32'h4000_0000, 0, m1a, rga);
    probe(32'h4000_0000, 1, m1b, rgb);
    check(m1a == m1b && rga == rgb, "R10 core independence", m1b, m1a);
    // fixed map under the default window
    rq(32'h0000_0000, 0); rq(32'hFBFF_FFFF, 1); rq(32'hFC00_0000, 0); rq(32'hFFFF_FFFF, 1);
    // R11 / R3 / R4: window 0x100..0x200
    wr(0, 'h100); wr(1, 'h200);
    probe(32'h0FFF_FFFF, 0, m1a, rga);
    check(m1a == 0 && rga == 0, "R4 below window", m1a, 0);
    probe(32'h1000_0000, 0, m1a, rga);
    check(m1a == 1 && rga == 1, "R3 window start", m1a, 1);
    rq(32'h1FFF_FFFF, 1); rq(32'h2000_0000, 0);
    // R12: offset bits ignored
    probe(32'h100F_FFFF, 1, m1b, rgb);
    check(m1b == m1a && rgb == rga, "R12 offset bits ignored", m1b, m1a);
    probe(32'h2000_0000, 0, m1a, rga);
    probe(32'h200F_FFFF, 0, m1b, rgb);
    check(m1a == 0 && m1b == 0 && rgb == rga, "R12 offset bits ignored at end", m1b, 0);
    // R5: empty windows
    wr(0, 'h300); wr(1, 'h300);
    probe(32'h3000_0000, 0, m1a, rga);
    check(m1a == 0, "R5 equal bounds", m1a, 0);
    wr(0, 'h400); wr(1, 'h100);
    probe(32'h2000_0000, 1, m1a, rga);
    check(m1a == 0 && rga == 0, "R5 inverted bounds", m1a, 0);
    // R11 / R3: full top, window over the fixed regions
    wr(0, 'hC00); wr(1, 'h1000);
    probe(32'hFFFF_FFFF, 0, m1a, rga);
    check(m1a == 1 && rga == 1, "R11 upper 0x1000 covers top", rga, 1);
    probe(32'hC000_0000, 1, m1a, rga);
    check(m1a == 1 && rga == 1, "R3 window overrides fabric tag", rga, 1);
    // R6 / R7 / R8 with window moved away
    wr(0, 'h000); wr(1, 'h010);
    probe(32'hC123_4567, 0, m1a, rga);
    check(rga == 2, "R6 fabric tag", rga, 2);
    probe(32'hFC00_0000, 0, m1a, rga);
    check(rga == 3, "R7 peripheral tag", rga, 3);
    probe(32'h8000_0000, 0, m1a, rga);
    check(rga == 0, "R8 other tag", rga, 0);
    // R9: write and request in the same cycle
    wr(0, 'h000); wr(1, 'h100);
    drive(1, 32'h0050_0000, 0, 1, 1, 'h000);
    rq(32'h0050_0000, 0);
    check(out_m1_req == 1, "R9 same-cycle request uses old bounds", out_m1_req, 1);
    drive(0, 32'h0, 0, 0, 0, 0);
    check(out_m0_req == 1 && out_m1_req == 0, "R9 next request uses new bounds", out_m1_req, 0);
    // random phase with boundary-biased addresses and concurrent writes
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [31:0] a;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = {ref_lo[11:0], 20'($urandom)};
        1: a = {12'(ref_hi - 1), 20'($urandom)};
        2: a = {ref_hi[11:0], 20'($urandom)};
        3: a = {12'hBFF + 12'($urandom_range(0, 2)), 20'($urandom)};
        4: a = {12'hFBF + 12'($urandom_range(0, 2)), 20'($urandom)};
        default: a = $urandom;
      endcase
      drive($urandom_range(0, 3) != 0, a, 1'($urandom),
            $urandom_range(0, 7) == 0, 1'($urandom), $urandom_range(0, 'h1000));
    end
    drive(0, 32'h0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule